// File: doc/BRIEF.md
# Multi-Lane PRBS Bit-Error Checker

This block receives test data that arrives in parallel, 1 to 8 bits per word, and measures how many of those bits differ from a pseudo-random binary sequence. The word strobe runs at the line bit rate divided by the number of active lanes. A configuration bit chooses whether each word is captured on the rising or the falling edge of the word clock.

The block has two operating modes. In merged mode, the active lanes of each word are joined into one serial stream, and a single checker handles the whole word in one clock cycle. In split mode, each active lane has its own checker with its own sequence order. Any checker can be switched off. Each checker synchronises itself to the incoming data and reports a lock flag. It also keeps a saturating count of compared bits and a saturating count of errored bits. Software clears both counts with a single pulse.

Top module: `prbs_lane_checker`

## Requirements
- R1: `cfg_width` holds the active lane count, 1 to 8 (0 is treated as 1 and values above `MAX_LANES` as `MAX_LANES`). Only `in_data` bits below that count are ever consumed, so data on higher bits has no effect on any lock flag or counter.
- R2: With `cfg_fall_edge`=0 a word is taken on the rising clock edge. With `cfg_fall_edge`=1 it is taken on the falling edge. Data present only around the other edge is never used.
- R3: In merged mode (`cfg_split`=0), checker 0 treats `in_data[0]` as the earliest bit of the word and higher indices as later bits. Each accepted word adds exactly `cfg_width` compared bits while locked.
- R4: In split mode, lane i (i below the lane count) feeds checker i only, with its own order `cfg_order[i]`. In merged mode, checkers 1 and up stay unlocked and keep counting nothing. The same holds in split mode for lanes at or above the lane count.
- R5: Order codes per checker are 0=OFF, 1=x^7+x^6+1, 2=x^10+x^7+1, 3=x^11+x^9+1, 4=x^15+x^14+1, 5=x^23+x^18+1 and 6=x^31+x^28+1. OFF keeps that checker unlocked with frozen counters, even when valid sequence data arrives.
- R6: A checker declares lock only after `LOCK_RUN` (default 64) consecutive correctly predicted bits. While unlocked it loads received bits into its register. Data from a different order never locks it.
- R7: While locked, the bit counter advances by one for every compared bit and the error counter advances by one for every bit that differs from the prediction, so a single flipped bit adds exactly one error.
- R8: A locked checker drops lock once more than `ERR_LIMIT` errors fall within one window of `WIN_LEN` compared bits. On clean data it then locks again.
- R9: Both counters saturate at all ones and never wrap.
- R10: Reset leaves every checker unlocked with zero counts. A one-cycle `cnt_clr` makes every count zero on the next cycle.
- R11: Any change of `cfg_split`, `cfg_width` or `cfg_order` unlocks every checker on the next cycle.
- R12: Words with `in_vld`=0 are ignored and neither advance the sequence nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | 1 = one checker per lane, 0 = merged stream |
| cfg_width | input | 4 | Active lane count |
| cfg_fall_edge | input | 1 | 1 = capture on falling edge |
| cfg_order | input | MAX_LANES x 3 | Sequence order code per checker |
| in_vld | input | 1 | Word strobe |
| in_data | input | MAX_LANES | Parallel data word |
| cnt_clr | input | 1 | Counter clear pulse |
| lock_o | output | MAX_LANES | Lock flag per checker |
| bit_cnt | output | MAX_LANES x CNT_W | Compared-bit counters |
| err_cnt | output | MAX_LANES x CNT_W | Errored-bit counters |

## Verification
The merged checker is driven with full 8-lane words and with 3-lane words whose upper bits carry random data. Exact bit counts show that only the active lanes are consumed, in the expected order. Split mode uses four different orders at once, with error flips placed on chosen lanes, so that crosstalk between checkers would show up as wrong per-lane error counts. An OFF checker is given a valid sequence and a mismatched order is tried, which separates "never locks" from "locks on any data". A run of inverted words, a short clean run below the lock threshold, gaps with random data and the strobe low, and words driven with random data around the unused clock edge each isolate the loss-of-lock, lock-threshold, strobe and edge-select behaviour.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [2:0] ORD_OFF = 3'd0;
  localparam logic [2:0] ORD_7   = 3'd1;
  localparam logic [2:0] ORD_10  = 3'd2;
  localparam logic [2:0] ORD_11  = 3'd3;
  localparam logic [2:0] ORD_15  = 3'd4;
  localparam logic [2:0] ORD_23  = 3'd5;
  localparam logic [2:0] ORD_31  = 3'd6;

  // hist[0] is the newest bit; hist[k-1] is the bit k positions back
  function automatic logic prbs_predict(input logic [30:0] hist, input logic [2:0] ord);
    logic p;
    case (ord)
      ORD_7:   p = hist[6]  ^ hist[5];
      ORD_10:  p = hist[9]  ^ hist[6];
      ORD_11:  p = hist[10] ^ hist[8];
      ORD_15:  p = hist[14] ^ hist[13];
      ORD_23:  p = hist[22] ^ hist[17];
      ORD_31:  p = hist[30] ^ hist[27];
      default: p = 1'b0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/prbs_lane_capture.sv
module prbs_lane_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fall_edge,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);
  timeunit 1ns;
  timeprecision 100ps;

  logic         rise_vld_q, neg_vld_q, fall_vld_q;
  logic [W-1:0] rise_dat_q, neg_dat_q, fall_dat_q;

  // rising-edge capture path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_vld_q <= 1'b0;
      rise_dat_q <= '0;
    end else begin
      rise_vld_q <= in_vld;
      rise_dat_q <= in_data;
    end
  end

  // falling-edge capture, then moved into the rising-edge domain
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_vld_q <= 1'b0;
      neg_dat_q <= '0;
    end else begin
      neg_vld_q <= in_vld;
      neg_dat_q <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_vld_q <= 1'b0;
      fall_dat_q <= '0;
    end else begin
      fall_vld_q <= neg_vld_q;
      fall_dat_q <= neg_dat_q;
    end
  end

  always_comb begin
    out_vld  = fall_edge ? fall_vld_q : rise_vld_q;
    out_data = fall_edge ? fall_dat_q : rise_dat_q;
  end
endmodule

// File: rtl/prbs_chk_core.sv
module prbs_chk_core
  import prbs_chk_pkg::*;
#(
  parameter int NB        = 8,
  parameter int LOCK_RUN  = 64,
  parameter int WIN_LEN   = 256,
  parameter int ERR_LIMIT = 16,
  parameter int CNT_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  input  logic                      clr,
  input  logic                      vld,
  input  logic [2:0]                ord,
  input  logic [$clog2(NB+1)-1:0]   nbits,
  input  logic [NB-1:0]             bits,
  output logic                      locked,
  output logic [CNT_W-1:0]          bit_cnt,
  output logic [CNT_W-1:0]          err_cnt
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NBW   = $clog2(NB + 1);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int WIN_W = $clog2(WIN_LEN + 1);

  logic [30:0]      hist_q, hist_d;
  logic             lock_q, lock_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [WIN_W-1:0] wbits_q, wbits_d, werrs_q, werrs_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d, ecnt_q, ecnt_d;
  logic [NBW-1:0]   add_b, add_e;
  logic [CNT_W:0]   bsum, esum;
  logic             pred, miss, halt, upd_en, cnt_en;

  assign halt   = restart | (ord == ORD_OFF);
  assign upd_en = halt | vld;

  // sequence tracking, lock and window logic, one bit per loop pass
  always_comb begin
    hist_d  = hist_q;
    lock_d  = lock_q;
    run_d   = run_q;
    wbits_d = wbits_q;
    werrs_d = werrs_q;
    add_b   = '0;
    add_e   = '0;
    pred    = 1'b0;
    miss    = 1'b0;
    if (halt) begin
      lock_d  = 1'b0;
      run_d   = '0;
      wbits_d = '0;
      werrs_d = '0;
    end else if (vld) begin
      for (int k = 0; k < NB; k++) begin
        if (k < int'(nbits)) begin
          pred = prbs_predict(hist_d, ord);
          miss = pred ^ bits[k];
          if (lock_d) begin
            hist_d  = {hist_d[29:0], pred};
            add_b   = add_b + NBW'(1);
            wbits_d = wbits_d + WIN_W'(1);
            if (miss) begin
              add_e   = add_e + NBW'(1);
              werrs_d = werrs_d + WIN_W'(1);
            end
            if (werrs_d > WIN_W'(ERR_LIMIT)) begin
              lock_d  = 1'b0;
              run_d   = '0;
              wbits_d = '0;
              werrs_d = '0;
            end else if (wbits_d == WIN_W'(WIN_LEN)) begin
              wbits_d = '0;
              werrs_d = '0;
            end
          end else begin
            hist_d = {hist_d[29:0], bits[k]};
            if (miss) run_d = '0;
            else      run_d = run_d + RUN_W'(1);
            if (run_d == RUN_W'(LOCK_RUN)) begin
              lock_d  = 1'b1;
              run_d   = '0;
              wbits_d = '0;
              werrs_d = '0;
            end
          end
        end
      end
    end
  end

  // saturating counters
  always_comb begin
    bsum   = {1'b0, bcnt_q} + {{(CNT_W + 1 - NBW){1'b0}}, add_b};
    esum   = {1'b0, ecnt_q} + {{(CNT_W + 1 - NBW){1'b0}}, add_e};
    cnt_en = clr | (add_b != '0);
    if (clr) begin
      bcnt_d = '0;
      ecnt_d = '0;
    end else begin
      bcnt_d = bsum[CNT_W] ? '1 : bsum[CNT_W-1:0];
      ecnt_d = esum[CNT_W] ? '1 : esum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      lock_q  <= 1'b0;
      run_q   <= '0;
      wbits_q <= '0;
      werrs_q <= '0;
    end else if (upd_en) begin
      hist_q  <= hist_d;
      lock_q  <= lock_d;
      run_q   <= run_d;
      wbits_q <= wbits_d;
      werrs_q <= werrs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      ecnt_q <= '0;
    end else if (cnt_en) begin
      bcnt_q <= bcnt_d;
      ecnt_q <= ecnt_d;
    end
  end

  assign locked  = lock_q;
  assign bit_cnt = bcnt_q;
  assign err_cnt = ecnt_q;
endmodule

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker
  import prbs_chk_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int LOCK_RUN  = 64,
  parameter int WIN_LEN   = 256,
  parameter int ERR_LIMIT = 16,
  parameter int CNT_W     = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_split,
  input  logic [$clog2(MAX_LANES+1)-1:0]      cfg_width,
  input  logic                                cfg_fall_edge,
  input  logic [MAX_LANES-1:0][2:0]           cfg_order,
  input  logic                                in_vld,
  input  logic [MAX_LANES-1:0]                in_data,
  input  logic                                cnt_clr,
  output logic [MAX_LANES-1:0]                lock_o,
  output logic [MAX_LANES-1:0][CNT_W-1:0]     bit_cnt,
  output logic [MAX_LANES-1:0][CNT_W-1:0]     err_cnt
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WID_W = $clog2(MAX_LANES + 1);
  localparam int CFG_W = 1 + WID_W + 3 * MAX_LANES;

  logic                 cap_vld;
  logic [MAX_LANES-1:0] cap_data;
  logic [WID_W-1:0]     eff_w;
  logic [CFG_W-1:0]     cfg_now, cfg_q;
  logic                 restart;

  prbs_lane_capture #(.W(MAX_LANES)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_edge(cfg_fall_edge),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (cap_vld),
    .out_data (cap_data)
  );

  // lane count clamp
  always_comb begin
    if (cfg_width == '0)                        eff_w = WID_W'(1);
    else if (cfg_width > WID_W'(MAX_LANES))     eff_w = WID_W'(MAX_LANES);
    else                                        eff_w = cfg_width;
  end

  // configuration change detector
  assign cfg_now = {cfg_split, cfg_width, cfg_order};
  assign restart = (cfg_now != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (restart) cfg_q <= cfg_now;
  end

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    if (i == 0) begin : g_head
      logic [WID_W-1:0]     nb;
      logic [MAX_LANES-1:0] bv;
      assign nb = cfg_split ? WID_W'(1) : eff_w;
      assign bv = cfg_split ? MAX_LANES'(cap_data[0]) : cap_data;
      prbs_chk_core #(
        .NB(MAX_LANES), .LOCK_RUN(LOCK_RUN), .WIN_LEN(WIN_LEN),
        .ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)
      ) u_core (
        .clk(clk), .rst_n(rst_n), .restart(restart), .clr(cnt_clr),
        .vld(cap_vld), .ord(cfg_order[0]), .nbits(nb), .bits(bv),
        .locked(lock_o[0]), .bit_cnt(bit_cnt[0]), .err_cnt(err_cnt[0])
      );
    end else begin : g_tail
      logic       act;
      logic [2:0] ord;
      assign act = cfg_split && (WID_W'(i) < eff_w);
      assign ord = act ? cfg_order[i] : ORD_OFF;
      prbs_chk_core #(
        .NB(1), .LOCK_RUN(LOCK_RUN), .WIN_LEN(WIN_LEN),
        .ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)
      ) u_core (
        .clk(clk), .rst_n(rst_n), .restart(restart), .clr(cnt_clr),
        .vld(cap_vld), .ord(ord), .nbits(1'b1), .bits(cap_data[i]),
        .locked(lock_o[i]), .bit_cnt(bit_cnt[i]), .err_cnt(err_cnt[i])
      );
    end
  end
endmodule

// File: rtl/prbs_lane_checker_sva.sv
module prbs_lane_checker_sva #(
  parameter int MAX_LANES = 8,
  parameter int CNT_W     = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cfg_split,
  input logic [$clog2(MAX_LANES+1)-1:0]  cfg_width,
  input logic [MAX_LANES-1:0][2:0]       cfg_order,
  input logic                            cnt_clr,
  input logic [MAX_LANES-1:0]            lock_o,
  input logic [MAX_LANES-1:0][CNT_W-1:0] bit_cnt,
  input logic [MAX_LANES-1:0][CNT_W-1:0] err_cnt
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [$bits(cfg_width)+3*MAX_LANES:0] cfg_vec;
  assign cfg_vec = {cfg_split, cfg_width, cfg_order};

  p_cfg_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_vec) |=> (lock_o == '0));

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_chk
    p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (bit_cnt[i] == '0) && (err_cnt[i] == '0));

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (bit_cnt[i] >= $past(bit_cnt[i])) && (err_cnt[i] >= $past(err_cnt[i])));

    p_err_le_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt[i] <= bit_cnt[i]);

    p_off_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_order[i] == 3'd0) |=> !lock_o[i]);

    if (i > 0) begin : g_tail
      p_merged_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_split |=> !lock_o[i]);
    end
  end
endmodule

bind prbs_lane_checker prbs_lane_checker_sva #(
  .MAX_LANES(MAX_LANES),
  .CNT_W    (CNT_W)
) u_sva (.*);

// File: tb/prbs_lane_checker_bench.sv
module prbs_lane_checker_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ML = 8;
  localparam int CW = 12;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  cfg_split, cfg_fall, cnt_clr, in_vld;
  logic [3:0]            cfg_width;
  logic [ML-1:0][2:0]    cfg_order, ords;
  logic [ML-1:0]         in_data, lock_o;
  logic [ML-1:0][CW-1:0] bit_cnt, err_cnt;

  typedef struct {int lane; int lk; int bits; int errs; string tag;} exp_t;
  exp_t        sbq[$];
  int          total = 0, bad = 0;
  bit          done = 1'b0;
  logic [30:0] gs[ML];
  logic [2:0]  fo[ML];

  always #2 clk = ~clk;

  prbs_lane_checker #(.MAX_LANES(ML), .CNT_W(CW)) u_prbs_lane_checker (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_width(cfg_width),
    .cfg_fall_edge(cfg_fall), .cfg_order(cfg_order), .in_vld(in_vld),
    .in_data(in_data), .cnt_clr(cnt_clr), .lock_o(lock_o),
    .bit_cnt(bit_cnt), .err_cnt(err_cnt)
  );

  // reference sequence generator, newest bit in gs[ln][0]
  function automatic logic gen(int ln, logic [2:0] o);
    logic nb;
    case (o)
      3'd1: nb = gs[ln][6]  ^ gs[ln][5];
      3'd2: nb = gs[ln][9]  ^ gs[ln][6];
      3'd3: nb = gs[ln][10] ^ gs[ln][8];
      3'd4: nb = gs[ln][14] ^ gs[ln][13];
      3'd5: nb = gs[ln][22] ^ gs[ln][17];
      3'd6: nb = gs[ln][30] ^ gs[ln][27];
      default: nb = 1'($urandom);
    endcase
    gs[ln] = {gs[ln][29:0], nb};
    return nb;
  endfunction

  function automatic logic [ML-1:0] make_word();
    logic [ML-1:0] w;
    for (int j = 0; j < ML; j++) begin
      if (!cfg_split) w[j] = (j < int'(cfg_width)) ? gen(0, fo[0]) : 1'($urandom);
      else            w[j] = (j < int'(cfg_width)) ? gen(j, fo[j]) : 1'($urandom);
    end
    return w;
  endfunction

  // word valid only around the selected edge, inverted around the other
  task automatic drive(input logic [ML-1:0] w, input logic v);
    if (!cfg_fall) begin
      @(negedge clk); #1; in_data = w; in_vld = v;
      @(posedge clk); #0.5; in_data = ~w; in_vld = ~v;
    end else begin
      @(posedge clk); #1; in_data = w; in_vld = v;
      @(negedge clk); #0.5; in_data = ~w; in_vld = ~v;
    end
  endtask

  task automatic send(int n, int fa, logic [ML-1:0] ma, int fb, logic [ML-1:0] mb, bit inv);
    for (int i = 0; i < n; i++) begin
      logic [ML-1:0] w;
      w = make_word();
      if (i == fa) w ^= ma;
      if (i == fb) w ^= mb;
      if (inv) w = ~w;
      drive(w, 1'b1);
    end
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) drive(ML'($urandom), 1'b0);
  endtask

  task automatic idle(int n);
    in_vld = 1'b0; in_data = '0;
    repeat (n) @(posedge clk);
  endtask

  task automatic clear();
    idle(3);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    idle(2);
  endtask

  task automatic setcfg(logic sp, logic [3:0] wd, logic fe);
    idle(2);
    @(negedge clk);
    cfg_split = sp; cfg_width = wd; cfg_fall = fe; cfg_order = ords;
    for (int j = 0; j < ML; j++) fo[j] = ords[j];
    idle(3);
  endtask

  task automatic expect_l(int ln, int lk, int b, int e, string tag);
    exp_t x;
    x.lane = ln; x.lk = lk; x.bits = b; x.errs = e; x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic sync();
    wait (sbq.size() == 0);
    @(posedge clk);
  endtask

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        exp_t x;
        x = sbq.pop_front();
        total++;
        if (lock_o[x.lane] !== x.lk[0]) begin
          bad++;
          $display("FAIL %s lane%0d lock actual=%b expected=%0d", x.tag, x.lane, lock_o[x.lane], x.lk);
        end
        if (x.bits >= 0) begin
          total++;
          if (bit_cnt[x.lane] !== CW'(x.bits)) begin
            bad++;
            $display("FAIL %s lane%0d bits actual=%0d expected=%0d", x.tag, x.lane, bit_cnt[x.lane], x.bits);
          end
        end
        if (x.errs >= 0) begin
          total++;
          if (err_cnt[x.lane] !== CW'(x.errs)) begin
            bad++;
            $display("FAIL %s lane%0d errs actual=%0d expected=%0d", x.tag, x.lane, err_cnt[x.lane], x.errs);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < ML; j++) begin
      gs[j] = {24'hA5C3E1, 7'(7'h13 + j)};
      fo[j] = 3'd0;
    end
    rst_n = 1'b0; cfg_split = 1'b0; cfg_width = 4'd8; cfg_fall = 1'b0;
    cfg_order = '0; ords = '0; in_vld = 1'b0; in_data = '0; cnt_clr = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    // R10: reset state
    for (int j = 0; j < ML; j++) expect_l(j, 0, 0, 0, "R10");
    sync();

    // R3 R7 R12: merged 8 lanes, PRBS7, strobe gaps, three flips
    ords = '{default: 3'd4}; ords[0] = 3'd1;
    setcfg(1'b0, 4'd8, 1'b0);
    send(40, -1, '0, -1, '0, 1'b0);
    clear();
    send(25, 3, 8'h01, 17, 8'h80, 1'b0);
    gap(5);
    send(25, 10, 8'h10, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, 400, 3, "R3 R7 R12");
    for (int j = 1; j < ML; j++) expect_l(j, 0, 0, 0, "R4");
    sync();

    // R1 R5: merged 3 lanes, PRBS23, random upper bits
    ords = '0; ords[0] = 3'd5;
    setcfg(1'b0, 4'd3, 1'b0);
    send(60, -1, '0, -1, '0, 1'b0);
    clear();
    send(100, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, 300, 0, "R1 R5");
    sync();

    // R4 R5 R7: split 4 lanes, four orders, lanes 4..7 above width
    ords = '{default: 3'd1};
    ords[0] = 3'd2; ords[1] = 3'd3; ords[2] = 3'd4; ords[3] = 3'd6;
    setcfg(1'b1, 4'd4, 1'b0);
    send(150, -1, '0, -1, '0, 1'b0);
    clear();
    send(80, 20, 8'h05, 55, 8'h04, 1'b0);
    idle(4);
    expect_l(0, 1, 80, 1, "R4 R5 R7");
    expect_l(1, 1, 80, 0, "R4 R5");
    expect_l(2, 1, 80, 2, "R4 R7");
    expect_l(3, 1, 80, 0, "R4 R5");
    for (int j = 4; j < ML; j++) expect_l(j, 0, 0, 0, "R1 R4");
    sync();

    // R5 R6: OFF lane given valid data, mismatched order on lane 1
    ords = '0; ords[1] = 3'd4;
    setcfg(1'b1, 4'd2, 1'b0);
    fo[0] = 3'd1; fo[1] = 3'd1;
    clear();
    send(150, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 0, 0, 0, "R5");
    expect_l(1, 0, 0, 0, "R6");
    sync();

    // R8: lock, error burst, relock
    ords = '0; ords[0] = 3'd6;
    setcfg(1'b0, 4'd8, 1'b0);
    send(40, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, -1, -1, "R8");
    sync();
    send(8, -1, '0, -1, '0, 1'b1);
    idle(4);
    expect_l(0, 0, -1, -1, "R8");
    sync();
    send(40, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, -1, -1, "R8");
    sync();

    // R9: saturation of the bit counter
    ords = '0; ords[0] = 3'd1;
    setcfg(1'b0, 4'd8, 1'b0);
    send(40, -1, '0, -1, '0, 1'b0);
    clear();
    send(600, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, 4095, 0, "R9");
    sync();

    // R11: order change and width change unlock
    ords[0] = 3'd2;
    setcfg(1'b0, 4'd8, 1'b0);
    expect_l(0, 0, -1, -1, "R11");
    sync();
    ords[0] = 3'd1;
    setcfg(1'b0, 4'd8, 1'b0);
    send(30, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, -1, -1, "R11");
    sync();
    setcfg(1'b0, 4'd4, 1'b0);
    expect_l(0, 0, -1, -1, "R11");
    sync();

    // R2 R6: falling-edge capture, lock threshold
    ords[0] = 3'd3;
    setcfg(1'b0, 4'd8, 1'b1);
    send(7, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 0, -1, -1, "R6");
    sync();
    send(33, -1, '0, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, -1, -1, "R6");
    sync();
    clear();
    send(30, 12, 8'h20, -1, '0, 1'b0);
    idle(4);
    expect_l(0, 1, 240, 1, "R2");
    sync();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule